// File: doc/BRIEF.md
# Scan-to-Bus Clock Domain Bridge

This bridge lets a scan register that runs on a slow test clock act as a master on an on-chip peripheral bus. The bus runs on its own faster clock, and the two clocks have no fixed relation. The scan side presents an address, write data, a write flag, byte lanes and a request. It then waits for an acknowledge. The bus side issues a strobe with the captured fields, waits for the addressed slave to acknowledge, and returns the read data. Each transfer is a single read or write, completed by a four-phase handshake across the two domains.

The request enters the bus domain through a multi-flop synchronizer. The fields travel without synchronization because the scan side keeps them steady for the whole transfer. When the slave acknowledges, the bus side latches the slave data and raises an intermediate acknowledge. It keeps that acknowledge high until the request has dropped. The intermediate acknowledge is synchronized back into the test-clock domain, where it becomes the scan acknowledge and loads the read-data register.

The scan address is wider than the bus address that the current peripherals decode. The spare upper bits travel to the bus untouched, so a wider decoder can use them later without changing the bridge.

Top module: `sbb_scan_bus_bridge`

## Requirements
- R1: After both resets, `sc_ack_o` and `bus_stb_o` are low.
- R2: While `bus_stb_o` is high, `bus_we_o`, `bus_wdata_o` and `bus_sel_o` equal the scan fields that were present when the request was seen. `bus_sel_o` bit i enables byte i (bits 8i+7..8i) of the data.
- R3: `bus_addr_o` carries the full scan address, spare upper bits included, bit for bit.
- R4: Each rising edge of `sc_req_i` produces exactly one strobe pulse, however long the request is held. No strobe is issued while the intermediate acknowledge is high.
- R5: `bus_stb_o` and the bus fields stay steady until the clock edge at which `bus_ack_i` is sampled high. The strobe is low from the next cycle on. A slave that needs N wait cycles sees the strobe for N+1 cycles before it acknowledges.
- R6: When `sc_ack_o` is high after a read, `sc_rdata_o` holds the word the slave returned with its acknowledge. It stays unchanged for as long as `sc_ack_o` stays high.
- R7: `sc_ack_o` rises only after the slave has acknowledged. It stays high for as long as `sc_req_i` is held. It falls within a few test-clock cycles after `sc_req_i` drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tck_rst | input | 1 | Synchronous active-high reset, test-clock domain |
| sc_req_i | input | 1 | Transfer request from the scan register, held until acknowledged |
| sc_addr_i | input | BUS_ADDR_W+SPARE_W | Scan address field, spare bits on top |
| sc_wdata_i | input | DATA_W | Scan write data |
| sc_we_i | input | 1 | 1 = write, 0 = read |
| sc_sel_i | input | SEL_W | Byte-lane enables |
| sc_ack_o | output | 1 | Transfer complete, test-clock domain |
| sc_rdata_o | output | DATA_W | Read data returned to the scan register |
| bclk | input | 1 | Peripheral bus clock |
| brst | input | 1 | Synchronous active-high reset, bus domain |
| bus_stb_o | output | 1 | Bus strobe |
| bus_we_o | output | 1 | Bus write enable |
| bus_addr_o | output | BUS_ADDR_W+SPARE_W | Bus address |
| bus_wdata_o | output | DATA_W | Bus write data |
| bus_sel_o | output | SEL_W | Bus byte-lane enables |
| bus_ack_i | input | 1 | Slave acknowledge |
| bus_rdata_i | input | DATA_W | Slave read data, valid with acknowledge |

## Verification
The bench builds the bridge with BUS_ADDR_W=8, SPARE_W=4, DATA_W=16 and SEL_W=2. With these values the spare nibble sits visibly above an 8-bit bus address, and two byte lanes allow a partial write that can be merged and then read back. The bus clock runs about nine times faster than the test clock. The slave model inserts zero, two and five wait cycles, which exercises strobe extension. A long request hold shows that a single request still yields exactly one strobe and a steady acknowledge.

// File: rtl/sbb_pkg.sv
package sbb_pkg;

  // Minimum synchronizer depth accepted by the bridge.
  localparam int SBB_MIN_SYNC = 2;

  // Bus-domain sequencing for one transfer.
  typedef enum logic [1:0] {
    B_IDLE   = 2'd0,  // waiting for a request
    B_STROBE = 2'd1,  // strobe out, waiting for slave acknowledge
    B_HOLD   = 2'd2   // intermediate acknowledge up, waiting for request drop
  } bus_state_t;

endpackage

// File: rtl/sbb_sync.sv
module sbb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q
);

  localparam int N = (STAGES < sbb_pkg::SBB_MIN_SYNC) ? sbb_pkg::SBB_MIN_SYNC : STAGES;

  logic [N-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= 1'b0;
    else     chain[0] <= d_async;
  end

  genvar g;
  generate
    for (g = 1; g < N; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= 1'b0;
        else     chain[g] <= chain[g-1];
      end
    end
  endgenerate

  assign q = chain[N-1];

endmodule

// File: rtl/sbb_bus_side.sv
module sbb_bus_side
  import sbb_pkg::*;
#(
  parameter int AW          = 12,
  parameter int DATA_W      = 32,
  parameter int SEL_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              bclk,
  input  logic              brst,
  input  logic              req_async,
  input  logic [AW-1:0]     addr_async,
  input  logic [DATA_W-1:0] wdata_async,
  input  logic              we_async,
  input  logic [SEL_W-1:0]  sel_async,
  output logic              bus_stb_o,
  output logic              bus_we_o,
  output logic [AW-1:0]     bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  output logic [SEL_W-1:0]  bus_sel_o,
  input  logic              bus_ack_i,
  input  logic [DATA_W-1:0] bus_rdata_i,
  output logic              xack_o,
  output logic [DATA_W-1:0] rdata_o
);

  logic       req_s;
  bus_state_t state;

  sbb_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk     (bclk),
    .rst     (brst),
    .d_async (req_async),
    .q       (req_s)
  );

  always_ff @(posedge bclk) begin
    if (brst) begin
      state       <= B_IDLE;
      bus_stb_o   <= 1'b0;
      bus_we_o    <= 1'b0;
      bus_addr_o  <= '0;
      bus_wdata_o <= '0;
      bus_sel_o   <= '0;
      xack_o      <= 1'b0;
      rdata_o     <= '0;
    end else begin
      case (state)
        B_IDLE: begin
          if (req_s) begin
            bus_addr_o  <= addr_async;
            bus_wdata_o <= wdata_async;
            bus_we_o    <= we_async;
            bus_sel_o   <= sel_async;
            bus_stb_o   <= 1'b1;
            state       <= B_STROBE;
          end
        end
        B_STROBE: begin
          if (bus_ack_i) begin
            bus_stb_o <= 1'b0;
            rdata_o   <= bus_rdata_i;
            xack_o    <= 1'b1;
            state     <= B_HOLD;
          end
        end
        B_HOLD: begin
          if (!req_s) begin
            xack_o <= 1'b0;
            state  <= B_IDLE;
          end
        end
        default: state <= B_IDLE;
      endcase
    end
  end

  AST_STB_STEADY: assert property (@(posedge bclk) disable iff (brst)
    bus_stb_o && !bus_ack_i |=> bus_stb_o && $stable(bus_addr_o) && $stable(bus_wdata_o) && $stable(bus_we_o)); // R5
  AST_STB_RELEASE: assert property (@(posedge bclk) disable iff (brst)
    bus_stb_o && bus_ack_i |=> !bus_stb_o && xack_o); // R5
  AST_NO_STB_WHILE_ACKED: assert property (@(posedge bclk) disable iff (brst)
    xack_o |-> !bus_stb_o); // R4
  AST_XACK_UNTIL_DROP: assert property (@(posedge bclk) disable iff (brst)
    xack_o && req_s |=> xack_o); // R7
  AST_RDATA_HELD: assert property (@(posedge bclk) disable iff (brst)
    xack_o && $past(xack_o) |-> $stable(rdata_o)); // R6

endmodule

// File: rtl/sbb_scan_side.sv
module sbb_scan_side #(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              tck,
  input  logic              tck_rst,
  input  logic              xack_async,
  input  logic [DATA_W-1:0] rdata_async,
  output logic              sc_ack_o,
  output logic [DATA_W-1:0] sc_rdata_o
);

  logic ack_s;

  sbb_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk     (tck),
    .rst     (tck_rst),
    .d_async (xack_async),
    .q       (ack_s)
  );

  // The bus side holds its read data until the request drops, so the
  // word is steady when the synchronized acknowledge first appears.
  always_ff @(posedge tck) begin
    if (tck_rst) begin
      sc_ack_o   <= 1'b0;
      sc_rdata_o <= '0;
    end else begin
      sc_ack_o <= ack_s;
      if (ack_s && !sc_ack_o) sc_rdata_o <= rdata_async;
    end
  end

  AST_SC_RDATA_STABLE: assert property (@(posedge tck) disable iff (tck_rst)
    sc_ack_o && $past(sc_ack_o) |-> $stable(sc_rdata_o)); // R6

endmodule

// File: rtl/sbb_scan_bus_bridge.sv
module sbb_scan_bus_bridge #(
  parameter int BUS_ADDR_W  = 24,
  parameter int SPARE_W     = 8,
  parameter int DATA_W      = 32,
  parameter int SEL_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                          tck,
  input  logic                          tck_rst,
  input  logic                          sc_req_i,
  input  logic [BUS_ADDR_W+SPARE_W-1:0] sc_addr_i,
  input  logic [DATA_W-1:0]             sc_wdata_i,
  input  logic                          sc_we_i,
  input  logic [SEL_W-1:0]              sc_sel_i,
  output logic                          sc_ack_o,
  output logic [DATA_W-1:0]             sc_rdata_o,
  input  logic                          bclk,
  input  logic                          brst,
  output logic                          bus_stb_o,
  output logic                          bus_we_o,
  output logic [BUS_ADDR_W+SPARE_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0]             bus_wdata_o,
  output logic [SEL_W-1:0]              bus_sel_o,
  input  logic                          bus_ack_i,
  input  logic [DATA_W-1:0]             bus_rdata_i
);

  localparam int AW = BUS_ADDR_W + SPARE_W;

  logic              xack;
  logic [DATA_W-1:0] rdata_hold;

  sbb_bus_side #(
    .AW          (AW),
    .DATA_W      (DATA_W),
    .SEL_W       (SEL_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_bus (
    .bclk        (bclk),
    .brst        (brst),
    .req_async   (sc_req_i),
    .addr_async  (sc_addr_i),
    .wdata_async (sc_wdata_i),
    .we_async    (sc_we_i),
    .sel_async   (sc_sel_i),
    .bus_stb_o   (bus_stb_o),
    .bus_we_o    (bus_we_o),
    .bus_addr_o  (bus_addr_o),
    .bus_wdata_o (bus_wdata_o),
    .bus_sel_o   (bus_sel_o),
    .bus_ack_i   (bus_ack_i),
    .bus_rdata_i (bus_rdata_i),
    .xack_o      (xack),
    .rdata_o     (rdata_hold)
  );

  sbb_scan_side #(
    .DATA_W      (DATA_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_scan (
    .tck         (tck),
    .tck_rst     (tck_rst),
    .xack_async  (xack),
    .rdata_async (rdata_hold),
    .sc_ack_o    (sc_ack_o),
    .sc_rdata_o  (sc_rdata_o)
  );

endmodule

// File: tb/tb_sbb_scan_bus_bridge.sv
`timescale 1ns/1ps
module tb_sbb_scan_bus_bridge;

  localparam int BAW = 8;
  localparam int SPW = 4;
  localparam int AW  = BAW + SPW;
  localparam int DW  = 16;
  localparam int SW  = 2;

  logic tck = 1'b0, bclk = 1'b0;
  logic tck_rst = 1'b1, brst = 1'b1;
  logic sc_req = 1'b0, sc_we = 1'b0;
  logic [AW-1:0] sc_addr = '0;
  logic [DW-1:0] sc_wdata = '0;
  logic [SW-1:0] sc_sel = '0;
  logic sc_ack_o;
  logic [DW-1:0] sc_rdata_o;
  logic bus_stb_o, bus_we_o;
  logic [AW-1:0] bus_addr_o;
  logic [DW-1:0] bus_wdata_o;
  logic [SW-1:0] bus_sel_o;
  logic bus_ack = 1'b0;
  logic [DW-1:0] bus_rdata = '0;

  always #2.0  bclk = ~bclk;   // 250 MHz bus clock
  always #18.5 tck  = ~tck;    // unrelated slow test clock

  sbb_scan_bus_bridge #(
    .BUS_ADDR_W(BAW), .SPARE_W(SPW), .DATA_W(DW), .SEL_W(SW), .SYNC_STAGES(2)
  ) dut (
    .tck(tck), .tck_rst(tck_rst), .sc_req_i(sc_req), .sc_addr_i(sc_addr),
    .sc_wdata_i(sc_wdata), .sc_we_i(sc_we), .sc_sel_i(sc_sel),
    .sc_ack_o(sc_ack_o), .sc_rdata_o(sc_rdata_o),
    .bclk(bclk), .brst(brst), .bus_stb_o(bus_stb_o), .bus_we_o(bus_we_o),
    .bus_addr_o(bus_addr_o), .bus_wdata_o(bus_wdata_o), .bus_sel_o(bus_sel_o),
    .bus_ack_i(bus_ack), .bus_rdata_i(bus_rdata)
  );

  int checks = 0, errors = 0;
  int slave_wait = 0;
  int wcnt = 0, hi_cnt = 0, last_hi = 0, stb_rises = 0;
  logic prev_stb = 1'b0;
  logic [AW-1:0] mon_addr;
  logic [DW-1:0] mon_wdata;
  logic [SW-1:0] mon_sel;
  logic mon_we;
  logic [DW-1:0] mem [16];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old, input logic [DW-1:0] nw, input logic [SW-1:0] s);
    logic [DW-1:0] r = old;
    for (int i = 0; i < SW; i++) if (s[i]) r[8*i +: 8] = nw[8*i +: 8];
    return r;
  endfunction

  // Bus slave model with programmable wait cycles.
  always @(posedge bclk) begin
    if (brst) begin
      bus_ack <= 1'b0; wcnt <= 0; hi_cnt <= 0; prev_stb <= 1'b0;
    end else begin
      prev_stb <= bus_stb_o;
      if (bus_stb_o && !prev_stb) stb_rises <= stb_rises + 1;
      bus_ack <= 1'b0;
      if (bus_stb_o && !bus_ack) begin
        if (wcnt == slave_wait) begin
          bus_ack   <= 1'b1;
          wcnt      <= 0;
          last_hi   <= hi_cnt + 1;
          hi_cnt    <= 0;
          mon_addr  <= bus_addr_o;
          mon_wdata <= bus_wdata_o;
          mon_sel   <= bus_sel_o;
          mon_we    <= bus_we_o;
          if (bus_we_o) mem[bus_addr_o[3:0]] <= merge(mem[bus_addr_o[3:0]], bus_wdata_o, bus_sel_o);
          else          bus_rdata <= mem[bus_addr_o[3:0]];
        end else begin
          wcnt   <= wcnt + 1;
          hi_cnt <= hi_cnt + 1;
        end
      end
    end
  end

  // One full scan-side transfer. Checks R7 at the drop of the request.
  task automatic xfer(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input logic [SW-1:0] s, input int hold, output logic [DW-1:0] rd);
    int n;
    @(negedge tck);
    sc_we = we; sc_addr = a; sc_wdata = d; sc_sel = s;
    @(negedge tck);
    chk(sc_ack_o == 1'b0, "R7 ack low before request", sc_ack_o, 0);
    sc_req = 1'b1;
    while (!sc_ack_o) @(negedge tck);
    rd = sc_rdata_o;
    for (int i = 0; i < hold; i++) begin
      @(negedge tck);
      if (!sc_ack_o || sc_rdata_o != rd) begin
        chk(sc_ack_o == 1'b1, "R7 ack held while request held", sc_ack_o, 1);
        chk(sc_rdata_o == rd, "R6 read data steady while acked", sc_rdata_o, rd);
      end
    end
    sc_req = 1'b0;
    n = 0;
    while (sc_ack_o && n < 12) begin @(negedge tck); n++; end
    chk(sc_ack_o == 1'b0, "R7 ack falls after request drop", sc_ack_o, 0);
    chk(bus_stb_o == 1'b0, "R5 strobe low after transfer", bus_stb_o, 0);
  endtask

  task automatic t_reset();
    @(negedge tck);
    chk(sc_ack_o == 1'b0, "R1 sc_ack_o after reset", sc_ack_o, 0);
    chk(bus_stb_o == 1'b0, "R1 bus_stb_o after reset", bus_stb_o, 0);
  endtask

  task automatic t_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [SW-1:0] s, input int w);
    logic [DW-1:0] rd;
    int r0 = stb_rises;
    slave_wait = w;
    xfer(1'b1, a, d, s, 0, rd);
    chk(mon_we == 1'b1, "R2 write flag on bus", mon_we, 1);
    chk(mon_wdata == d, "R2 write data on bus", mon_wdata, d);
    chk(mon_sel == s, "R2 byte lanes on bus", mon_sel, s);
    chk(mon_addr == a, "R3 full address incl. spare bits", mon_addr, a);
    chk(stb_rises == r0 + 1, "R4 one strobe per request", stb_rises - r0, 1);
    chk(last_hi == w + 1, "R5 strobe held through wait cycles", last_hi, w + 1);
  endtask

  task automatic t_read(input logic [AW-1:0] a, input logic [DW-1:0] exp, input int w);
    logic [DW-1:0] rd;
    int r0 = stb_rises;
    slave_wait = w;
    xfer(1'b0, a, '0, '1, 0, rd);
    chk(mon_we == 1'b0, "R2 read flag on bus", mon_we, 0);
    chk(rd == exp, "R6 read data returned", rd, exp);
    chk(stb_rises == r0 + 1, "R4 one strobe per read", stb_rises - r0, 1);
    chk(last_hi == w + 1, "R5 strobe length on read", last_hi, w + 1);
  endtask

  task automatic t_long_hold(input logic [AW-1:0] a, input logic [DW-1:0] exp);
    logic [DW-1:0] rd;
    int r0 = stb_rises;
    slave_wait = 1;
    xfer(1'b0, a, '0, '1, 15, rd);
    chk(rd == exp, "R6 read data on long hold", rd, exp);
    chk(stb_rises == r0 + 1, "R4 single strobe on long hold", stb_rises - r0, 1);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 16'h1000 + 16'(i);
    repeat (4) @(negedge tck);
    tck_rst = 1'b0; brst = 1'b0;
    t_reset();
    t_write(12'h003, 16'hBEEF, 2'b11, 0);
    t_write(12'hA07, 16'h5A3C, 2'b11, 5);
    t_read (12'h003, 16'hBEEF, 2);
    t_write(12'h507, 16'h00C3, 2'b01, 0);          // low byte only
    t_read (12'h007, merge(16'h5A3C, 16'h00C3, 2'b01), 0);
    t_long_hold(12'hF0C, 16'h100C);
    t_read (12'h00C, 16'h100C, 5);
    t_write(12'h30C, 16'h7700, 2'b10, 2);          // high byte only
    t_read (12'h00C, merge(16'h100C, 16'h7700, 2'b10), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge bclk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule